// File: doc/BRIEF.md
# Priority-Muxed Eight-Pin Port Controller

This block controls an eight-pin bidirectional port whose pins can be handed over to on-chip peripherals. The pins are split into two four-pin groups. Each group decides on its own who drives it. A stall-detect unit wins over a motor-control PWM pair, and the PWM pair wins over general-purpose I/O. The upper group answers to the first stall-detect unit and to PWM channels 7/6. The lower group answers to the second stall-detect unit and to PWM channels 5/4.

Software sees two registers on a simple register bus: a data register and a direction register. Writes are strobed and take effect at the next clock edge, while reads are combinational. When a pin is an output, reading the data register gives back the stored bit. When a pin is an input, the read gives a constant 1 if slew-rate control is on for that pin, and otherwise the pin level after a two-flop synchronizer. While reset is asserted, every pin is a high-impedance input.

Top module: `pmux_port`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is all zeros whatever the peripheral inputs are, and after reset both registers read back as 0x00.
- R2: A write strobe at offset 0x40 loads the data register and a write strobe at offset 0x42 loads the direction register, both at the next rising clock edge; reading offset 0x42 returns the direction register.
- R3: In a group whose stall-detect and PWM enables are both low, each pin's `pin_oe` equals its direction bit and its `pin_out` equals its data bit.
- R4: In a group whose stall-detect enable is high, `pin_out` and `pin_oe` equal that group's `stall_out` and `stall_oe` bits, whatever the state of the PWM enable.
- R5: In a group whose stall-detect enable is low and PWM enable is high, `pin_out` and `pin_oe` equal that group's `pwm_out` and `pwm_oe` bits.
- R6: Reading offset 0x40 returns the stored data bit for every pin whose direction bit is 1 (1 = output).
- R7: Reading offset 0x40 returns 1 for every pin whose direction bit is 0 and whose `slew_en` bit is 1.
- R8: Reading offset 0x40 returns the `pin_in` level for input pins with `slew_en` low, two rising edges after that level is applied and not after only one.
- R9: While a peripheral owns a group, writes to both registers are still accepted and read back, and they leave `pin_out` and `pin_oe` of that group unchanged.
- R10: The groups are independent: enable bit 1 governs pins [7:4] and enable bit 0 governs pins [3:0].
- R11: Any other offset reads as 0x00, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| slew_en | input | 8 | Per-pin slew-rate control enable |
| stall_en | input | 2 | Stall-detect enables, bit 1 upper group, bit 0 lower group |
| stall_out | input | 8 | Stall-detect pin output values |
| stall_oe | input | 8 | Stall-detect pin output enables |
| pwm_en | input | 2 | PWM pair enables, bit 1 upper group, bit 0 lower group |
| pwm_out | input | 8 | PWM pin output values |
| pwm_oe | input | 8 | PWM pin output enables |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The ownership and read-path assertions assume that the enables, the peripheral signals, the slew enables and the bus address only change away from the rising edge, so the combinational outputs have settled by the time they are sampled. The write assertions assume that the write strobe is only raised for one cycle at a time, together with a stable address and data. The bench drives every input on the falling edge and holds it through the next rising edge, and it applies pad levels long enough for the synchronizer to pass them through. As a result, no property ever sees a half-settled input.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

   typedef enum logic [1:0] {
      OWN_GPIO  = 2'd0,
      OWN_PWM   = 2'd1,
      OWN_STALL = 2'd2
   } owner_e;

   function automatic owner_e pick_owner(input logic stall_on, input logic pwm_on);
      if (stall_on)    return OWN_STALL;
      else if (pwm_on) return OWN_PWM;
      else             return OWN_GPIO;
   endfunction

endpackage

// File: rtl/pmux_regs.sv
module pmux_regs #(
   parameter int                WIDTH    = 8,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] DATA_OFS = 'h40,
   parameter logic [ADDR_W-1:0] DIR_OFS  = 'h42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q
);

   if (DATA_OFS == DIR_OFS) begin : g_bad_map
      $error("pmux_regs: register offsets collide");
   end

   logic hit_data, hit_dir;
   assign hit_data = bus_wr && (bus_addr == DATA_OFS);
   assign hit_dir  = bus_wr && (bus_addr == DIR_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else begin
         if (hit_data) data_q <= bus_wdata;
         if (hit_dir)  dir_q  <= bus_wdata;
      end
   end

   assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_OFS) |=> (data_q == $past(bus_wdata)));

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_OFS) |=> (dir_q == $past(bus_wdata)));

   assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != DATA_OFS && bus_addr != DIR_OFS) |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/pmux_sync.sv
module pmux_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_depth
      $error("pmux_sync: at least two stages are required");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_in;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[k] <= '0;
         else        stage_q[k] <= stage_q[k-1];
      end

      assert_sync_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (stage_q[k] == $past(stage_q[k-1])));
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pmux_group.sv
module pmux_group
   import pmux_pkg::*;
#(
   parameter int GW = 4
) (
   input  logic          stall_on,
   input  logic          pwm_on,
   input  logic [GW-1:0] gpio_out,
   input  logic [GW-1:0] gpio_oe,
   input  logic [GW-1:0] stall_out,
   input  logic [GW-1:0] stall_oe,
   input  logic [GW-1:0] pwm_out,
   input  logic [GW-1:0] pwm_oe,
   output logic [GW-1:0] grp_out,
   output logic [GW-1:0] grp_oe
);

   owner_e owner;
   assign owner = pick_owner(stall_on, pwm_on);

   always_comb begin
      unique case (owner)
         OWN_STALL: begin grp_out = stall_out; grp_oe = stall_oe; end
         OWN_PWM:   begin grp_out = pwm_out;   grp_oe = pwm_oe;   end
         default:   begin grp_out = gpio_out;  grp_oe = gpio_oe;  end
      endcase
   end

endmodule

// File: rtl/pmux_port.sv
module pmux_port #(
   parameter int                PIN_COUNT   = 8,
   parameter int                GROUP_W     = 4,
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] DATA_OFS    = 'h40,
   parameter logic [ADDR_W-1:0] DIR_OFS     = 'h42,
   parameter int                SYNC_STAGES = 2,
   localparam int               GROUPS      = PIN_COUNT / GROUP_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [PIN_COUNT-1:0] bus_wdata,
   output logic [PIN_COUNT-1:0] bus_rdata,
   input  logic [PIN_COUNT-1:0] slew_en,
   input  logic [GROUPS-1:0]    stall_en,
   input  logic [PIN_COUNT-1:0] stall_out,
   input  logic [PIN_COUNT-1:0] stall_oe,
   input  logic [GROUPS-1:0]    pwm_en,
   input  logic [PIN_COUNT-1:0] pwm_out,
   input  logic [PIN_COUNT-1:0] pwm_oe,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);

   if (GROUP_W < 1 || (PIN_COUNT % GROUP_W) != 0) begin : g_bad_split
      $error("pmux_port: PIN_COUNT must be a multiple of GROUP_W");
   end

   logic [PIN_COUNT-1:0] data_q, dir_q, pin_sync;
   logic [PIN_COUNT-1:0] mux_out, mux_oe;
   logic [PIN_COUNT-1:0] port_view;

   pmux_regs #(
      .WIDTH(PIN_COUNT), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q)
   );

   pmux_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int LO = g * GROUP_W;

      pmux_group #(.GW(GROUP_W)) grp_i (
         .stall_on (stall_en[g]),
         .pwm_on   (pwm_en[g]),
         .gpio_out (data_q[LO +: GROUP_W]),
         .gpio_oe  (dir_q[LO +: GROUP_W]),
         .stall_out(stall_out[LO +: GROUP_W]),
         .stall_oe (stall_oe[LO +: GROUP_W]),
         .pwm_out  (pwm_out[LO +: GROUP_W]),
         .pwm_oe   (pwm_oe[LO +: GROUP_W]),
         .grp_out  (mux_out[LO +: GROUP_W]),
         .grp_oe   (mux_oe[LO +: GROUP_W])
      );

      assert_stall_owns_R4: assert property (@(posedge clk) disable iff (!rst_n)
         stall_en[g] |-> (pin_out[LO +: GROUP_W] == stall_out[LO +: GROUP_W] &&
                          pin_oe[LO +: GROUP_W]  == stall_oe[LO +: GROUP_W]));

      assert_pwm_owns_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!stall_en[g] && pwm_en[g]) |-> (pin_out[LO +: GROUP_W] == pwm_out[LO +: GROUP_W] &&
                                          pin_oe[LO +: GROUP_W]  == pwm_oe[LO +: GROUP_W]));

      assert_gpio_owns_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!stall_en[g] && !pwm_en[g]) |-> (pin_out[LO +: GROUP_W] == data_q[LO +: GROUP_W] &&
                                           pin_oe[LO +: GROUP_W]  == dir_q[LO +: GROUP_W]));
   end

   assign pin_out = mux_out;
   assign pin_oe  = rst_n ? mux_oe : '0;

   always_comb begin
      for (int i = 0; i < PIN_COUNT; i++) begin
         if (dir_q[i])        port_view[i] = data_q[i];
         else if (slew_en[i]) port_view[i] = 1'b1;
         else                 port_view[i] = pin_sync[i];
      end
   end

   always_comb begin
      if (bus_addr == DATA_OFS)     bus_rdata = port_view;
      else if (bus_addr == DIR_OFS) bus_rdata = dir_q;
      else                          bus_rdata = '0;
   end

   always_comb begin
      if (!rst_n) begin
         assert_reset_hiz_R1: assert (pin_oe == '0);
      end
   end

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin_chk
      assert_read_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == DATA_OFS && dir_q[p]) |-> (bus_rdata[p] == data_q[p]));

      assert_read_slew_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == DATA_OFS && !dir_q[p] && slew_en[p]) |-> bus_rdata[p]);
   end

   assert_read_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != DATA_OFS && bus_addr != DIR_OFS) |-> (bus_rdata == '0));

endmodule

// File: tb/pmux_port_tb.sv
`timescale 1ns/1ps
module pmux_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
   logic       bus_wr = 1'b0;
   logic [7:0] slew_en = 8'h00;
   logic [1:0] stall_en = 2'b00, pwm_en = 2'b00;
   logic [7:0] stall_out = 8'h00, stall_oe = 8'h00, pwm_out = 8'h00, pwm_oe = 8'h00;
   logic [7:0] pin_in = 8'h00, pin_out, pin_oe;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pmux_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slew_en(slew_en),
      .stall_en(stall_en), .stall_out(stall_out), .stall_oe(stall_oe),
      .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // {stall_en, pwm_en, expected pin_out, expected pin_oe}
   // with data=A5 dir=3C, stall C3/99, pwm 66/E7
   localparam logic [19:0] VEC [8] = '{
      {2'b00, 2'b00, 8'hA5, 8'h3C},
      {2'b11, 2'b00, 8'hC3, 8'h99},
      {2'b00, 2'b11, 8'h66, 8'hE7},
      {2'b11, 2'b11, 8'hC3, 8'h99},
      {2'b10, 2'b01, 8'hC6, 8'h97},
      {2'b01, 2'b10, 8'h63, 8'hE9},
      {2'b00, 2'b10, 8'h65, 8'hEC},
      {2'b10, 2'b00, 8'hC5, 8'h9C}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      // R1: reset holds all pins as inputs even with peripherals asserting
      stall_en = 2'b11; stall_oe = 8'hFF; pwm_en = 2'b11; pwm_oe = 8'hFF;
      repeat (3) @(negedge clk);
      #1 check("R1 reset oe", pin_oe, 8'h00);
      stall_en = 2'b00; pwm_en = 2'b00; stall_oe = 8'h00; pwm_oe = 8'h00;
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      bus_read(8'h42, rd); check("R1 dir reset", rd, 8'h00);
      slew_en = 8'h00;
      bus_write(8'h42, 8'hFF);
      bus_read(8'h40, rd); check("R1 data reset", rd, 8'h00);

      // R2 and R6
      bus_write(8'h40, 8'hA5);
      bus_read(8'h40, rd); check("R2 R6 data readback", rd, 8'hA5);
      bus_write(8'h42, 8'h3C);
      bus_read(8'h42, rd); check("R2 dir readback", rd, 8'h3C);

      // Ownership table: R3 R4 R5 R10
      stall_out = 8'hC3; stall_oe = 8'h99; pwm_out = 8'h66; pwm_oe = 8'hE7;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         stall_en = VEC[i][19:18];
         pwm_en   = VEC[i][17:16];
         #1;
         check($sformatf("R3 R4 R5 R10 out vec%0d", i), pin_out, VEC[i][15:8]);
         check($sformatf("R3 R4 R5 R10 oe vec%0d", i), pin_oe, VEC[i][7:0]);
      end

      // R9: writes accepted while peripherals own both groups
      @(negedge clk); stall_en = 2'b11; pwm_en = 2'b00;
      bus_write(8'h40, 8'h00);
      bus_write(8'h42, 8'hFF);
      #1 check("R9 pins kept out", pin_out, 8'hC3);
      check("R9 pins kept oe", pin_oe, 8'h99);
      bus_read(8'h40, rd); check("R9 data readback", rd, 8'h00);
      bus_read(8'h42, rd); check("R9 dir readback", rd, 8'hFF);
      @(negedge clk); stall_en = 2'b00;
      #1 check("R3 gpio resumes oe", pin_oe, 8'hFF);

      // R7: inputs with slew control read 1
      bus_write(8'h42, 8'h00);
      slew_en = 8'hFF;
      bus_read(8'h40, rd); check("R7 slew reads one", rd, 8'hFF);

      // R8: synchronizer latency
      slew_en = 8'h00;
      @(negedge clk); pin_in = 8'h3C;
      @(negedge clk);
      bus_read(8'h40, rd); check("R8 one edge not yet", rd, 8'h00);
      @(negedge clk);
      bus_read(8'h40, rd); check("R8 two edges", rd, 8'h3C);

      // R6 R7 R8 mixed per pin
      bus_write(8'h40, 8'hA5);
      bus_write(8'h42, 8'h0F);
      slew_en = 8'h30;
      bus_read(8'h40, rd); check("R6 R7 R8 mixed", rd, 8'h35);

      // R11: unmapped offset
      bus_write(8'h41, 8'hFF);
      bus_read(8'h41, rd); check("R11 unmapped read", rd, 8'h00);
      bus_read(8'h42, rd); check("R11 dir untouched", rd, 8'h0F);
      bus_write(8'h42, 8'hFF);
      bus_read(8'h40, rd); check("R11 data untouched", rd, 8'hA5);

      // R1: reset again clears registers and releases pins
      @(negedge clk) rst_n = 1'b0;
      #1 check("R1 mid-run reset oe", pin_oe, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      bus_read(8'h42, rd); check("R1 dir cleared", rd, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule